// File: doc/BRIEF.md
# Single-Cycle Subset RISC Processor

This block is a 32-bit processor that completes one instruction every clock cycle. It covers a small load/store subset: word load and store, the register-register operations add, subtract, AND, OR, NOR and signed set-less-than, branch-if-equal, and an absolute jump. A program counter drives a local instruction array. The register file, ALU and local data array then work in one combinational pass, and all state changes together on the rising clock edge.

Decoding happens in two steps. The opcode first picks a coarse ALU class: add for memory access, subtract for compare, or "consult funct" for register-register operations. That class and the funct field then pick a 4-bit ALU operation. A side port fills both memory arrays while the core is held in reset. Debug outputs show the current PC, the register write the current instruction will make and the data store it will make, so a bench can follow execution one instruction at a time.

Top module: `subset_cpu`

## Requirements
- R1: While `rst` is high at a rising edge, the PC and all 32 registers clear to zero. While `rst` is high, `dbg_rf_we` and `dbg_dm_we` stay low.
- R2: An instruction that is not a taken branch and not a jump advances the PC by 4. The instruction fetched is word (PC / 4) modulo the instruction array depth.
- R3: Opcode 0 (bits 31:26) writes register rd (bits 15:11) with rs (bits 25:21) op rt (bits 20:16). The operation comes from funct (bits 5:0): 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x27 NOR, 0x2A signed less-than (result 1 or 0). Any other funct writes 0.
- R4: Opcode 35 writes register rt with data word ((rs + sign-extended bits 15:0) / 4) modulo the data array depth.
- R5: Opcode 43 stores rt at that same data word and reports the full byte address. It writes no register.
- R6: Opcode 4 compares rs and rt. When they are equal, the next PC is PC + 4 + (sign-extended bits 15:0 shifted left by 2). When they differ, the next PC is PC + 4. It writes neither register nor memory.
- R7: Opcode 2 loads the PC with bits 31:28 of PC + 4, then bits 25:0 of the instruction, then two zero bits.
- R8: Register 0 always reads as zero. A write aimed at it is dropped and is not reported on `dbg_rf_we`.
- R9: Any other opcode writes nothing and advances the PC by 4.
- R10: The debug write outputs describe the instruction at `dbg_pc` in the same cycle. The register, memory and PC update occurs at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Side-port write strobe for the memory arrays |
| ld_to_data | input | 1 | 1 selects the data array, 0 the instruction array |
| ld_addr | input | LOAD_AW | Word index for the side-port write |
| ld_word | input | 32 | Word written through the side port |
| dbg_pc | output | 32 | Address of the instruction now executing |
| dbg_rf_we | output | 1 | Current instruction writes a nonzero register |
| dbg_rf_waddr | output | 5 | Destination register number |
| dbg_rf_wdata | output | 32 | Value to be written to the register |
| dbg_dm_we | output | 1 | Current instruction stores to data memory |
| dbg_dm_addr | output | 32 | Byte address computed for load or store |
| dbg_dm_wdata | output | 32 | Store data |

## Verification
Every debug output is combinational from the current PC and the register state, so the bench checks it in the same cycle, one time unit after the falling edge. The register, memory and PC effects of that instruction take hold at the following rising edge. They are checked one sample later, through the next `dbg_pc` and the operands that later instructions read. A reference model in the bench steps once per sample and compares its expected PC, register write and store against the outputs before it advances. The PC check is credited to the requirement of the instruction that produced that PC.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN = 32;

  localparam logic [5:0] OP_RR    = 6'd0;
  localparam logic [5:0] OP_LOAD  = 6'd35;
  localparam logic [5:0] OP_STORE = 6'd43;
  localparam logic [5:0] OP_BEQ   = 6'd4;
  localparam logic [5:0] OP_JUMP  = 6'd2;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_NOR = 6'h27;
  localparam logic [5:0] FN_SLT = 6'h2a;

  typedef enum logic [1:0] {
    CLS_ADD   = 2'b00,
    CLS_SUB   = 2'b01,
    CLS_FUNCT = 2'b10
  } alu_class_e;

  typedef enum logic [3:0] {
    ALU_AND  = 4'b0000,
    ALU_OR   = 4'b0001,
    ALU_ADD  = 4'b0010,
    ALU_SUB  = 4'b0110,
    ALU_SLT  = 4'b0111,
    ALU_NOR  = 4'b1100,
    ALU_NULL = 4'b1111
  } alu_op_e;

  typedef struct packed {
    logic dst_is_rd;
    logic b_is_imm;
    logic wb_from_mem;
    logic reg_wr;
    logic mem_rd;
    logic mem_wr;
    logic branch;
    logic jump;
  } ctrl_t;

  function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
    return {{(XLEN-16){v[15]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] branch_dest(input logic [XLEN-1:0] pc4,
                                                  input logic [15:0] off);
    return pc4 + (sext16(off) << 2);
  endfunction

  function automatic logic [XLEN-1:0] jump_dest(input logic [XLEN-1:0] pc4,
                                                input logic [25:0] idx);
    return {pc4[XLEN-1:XLEN-4], idx, 2'b00};
  endfunction
endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl,
  output alu_op_e    alu_op
);
  alu_class_e cls;

  always_comb begin
    ctrl = '0;
    cls  = CLS_ADD;
    unique case (opcode)
      OP_RR: begin
        ctrl.dst_is_rd = 1'b1;
        ctrl.reg_wr    = 1'b1;
        cls            = CLS_FUNCT;
      end
      OP_LOAD: begin
        ctrl.b_is_imm    = 1'b1;
        ctrl.wb_from_mem = 1'b1;
        ctrl.reg_wr      = 1'b1;
        ctrl.mem_rd      = 1'b1;
      end
      OP_STORE: begin
        ctrl.b_is_imm = 1'b1;
        ctrl.mem_wr   = 1'b1;
      end
      OP_BEQ: begin
        ctrl.branch = 1'b1;
        cls         = CLS_SUB;
      end
      OP_JUMP: ctrl.jump = 1'b1;
      default: ctrl = '0;
    endcase
  end

  always_comb begin
    alu_op = ALU_NULL;
    case (cls)
      CLS_ADD: alu_op = ALU_ADD;
      CLS_SUB: alu_op = ALU_SUB;
      CLS_FUNCT: begin
        case (funct)
          FN_ADD:  alu_op = ALU_ADD;
          FN_SUB:  alu_op = ALU_SUB;
          FN_AND:  alu_op = ALU_AND;
          FN_OR:   alu_op = ALU_OR;
          FN_NOR:  alu_op = ALU_NOR;
          FN_SLT:  alu_op = ALU_SLT;
          default: alu_op = ALU_NULL;
        endcase
      end
      default: alu_op = ALU_NULL;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    case (op)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      ALU_NOR: y = ~(a | b);
      default: y = '0;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra,
  input  logic [AW-1:0] rb,
  output logic [W-1:0]  qa,
  output logic [W-1:0]  qb
);
  logic [W-1:0] q [NREG];

  assign q[0] = '0;

  for (genvar i = 1; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                          q[i] <= '0;
      else if (we && waddr == AW'(i))   q[i] <= wdata;
    end
  end

  assign qa = q[ra];
  assign qb = q[rb];
endmodule

// File: rtl/subset_cpu.sv
module subset_cpu
  import sc_pkg::*;
#(
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 6,
  localparam int LOAD_AW = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ld_en,
  input  logic               ld_to_data,
  input  logic [LOAD_AW-1:0] ld_addr,
  input  logic [31:0]        ld_word,
  output logic [31:0]        dbg_pc,
  output logic               dbg_rf_we,
  output logic [4:0]         dbg_rf_waddr,
  output logic [31:0]        dbg_rf_wdata,
  output logic               dbg_dm_we,
  output logic [31:0]        dbg_dm_addr,
  output logic [31:0]        dbg_dm_wdata
);
  localparam int IWORDS = 2 ** IMEM_AW;
  localparam int DWORDS = 2 ** DMEM_AW;

  logic [XLEN-1:0] imem [IWORDS];
  logic [XLEN-1:0] dmem [DWORDS];

  logic [XLEN-1:0] pc_q, pc_plus4, pc_next;
  logic [XLEN-1:0] instr;
  logic [5:0]      opcode, funct;
  logic [4:0]      rs_a, rt_a, rd_a, wb_addr;
  logic [15:0]     imm16;
  ctrl_t           ctrl;
  alu_op_e         alu_op;
  logic [XLEN-1:0] rs_val, rt_val, alu_b, alu_y, dm_rdata, wb_data;
  logic            alu_zero, br_taken, is_jump, rf_we, dm_we;

  // fetch and field split
  assign instr  = imem[pc_q[IMEM_AW+1:2]];
  assign opcode = instr[31:26];
  assign rs_a   = instr[25:21];
  assign rt_a   = instr[20:16];
  assign rd_a   = instr[15:11];
  assign imm16  = instr[15:0];
  assign funct  = instr[5:0];

  sc_decode u_dec (
    .opcode (opcode),
    .funct  (funct),
    .ctrl   (ctrl),
    .alu_op (alu_op)
  );

  sc_regfile #(.W(XLEN), .NREG(32)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (rf_we),
    .waddr (wb_addr),
    .wdata (wb_data),
    .ra    (rs_a),
    .rb    (rt_a),
    .qa    (rs_val),
    .qb    (rt_val)
  );

  assign alu_b = ctrl.b_is_imm ? sext16(imm16) : rt_val;

  sc_alu #(.W(XLEN)) u_alu (
    .a    (rs_val),
    .b    (alu_b),
    .op   (alu_op),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // data memory and write-back selection
  assign dm_rdata = ctrl.mem_rd ? dmem[alu_y[DMEM_AW+1:2]] : '0;
  assign wb_addr  = ctrl.dst_is_rd ? rd_a : rt_a;
  assign wb_data  = ctrl.wb_from_mem ? dm_rdata : alu_y;
  assign rf_we    = ctrl.reg_wr & ~rst;
  assign dm_we    = ctrl.mem_wr & ~rst;

  always_ff @(posedge clk) begin
    if (ld_en && !ld_to_data) imem[ld_addr[IMEM_AW-1:0]] <= ld_word;
  end

  always_ff @(posedge clk) begin
    if (ld_en && ld_to_data) dmem[ld_addr[DMEM_AW-1:0]] <= ld_word;
    else if (dm_we)          dmem[alu_y[DMEM_AW+1:2]]   <= rt_val;
  end

  // next-PC selection
  assign br_taken = ctrl.branch & alu_zero;
  assign is_jump  = ctrl.jump;
  assign pc_plus4 = pc_q + 32'd4;

  always_comb begin
    if (is_jump)       pc_next = jump_dest(pc_plus4, instr[25:0]);
    else if (br_taken) pc_next = branch_dest(pc_plus4, imm16);
    else               pc_next = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  assign dbg_pc       = pc_q;
  assign dbg_rf_we    = rf_we & (wb_addr != 5'd0);
  assign dbg_rf_waddr = wb_addr;
  assign dbg_rf_wdata = wb_data;
  assign dbg_dm_we    = dm_we;
  assign dbg_dm_addr  = alu_y;
  assign dbg_dm_wdata = rt_val;
endmodule

// File: rtl/sc_checker.sv
module sc_checker (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic [31:0] instr,
  input logic        taken,
  input logic        jump,
  input logic        rf_we,
  input logic        dm_we,
  input logic [4:0]  rs_addr,
  input logic [31:0] rs_val,
  input logic [31:0] rt_val
);
  logic known_op;
  assign known_op = (instr[31:26] == 6'd0)  || (instr[31:26] == 6'd35) ||
                    (instr[31:26] == 6'd43) || (instr[31:26] == 6'd4)  ||
                    (instr[31:26] == 6'd2);

  a_r2_sequential_pc: assert property (@(posedge clk) disable iff (rst)
    (!taken && !jump) |=> (pc == $past(pc) + 32'd4));

  a_r7_jump_field: assert property (@(posedge clk) disable iff (rst)
    jump |=> (pc[27:0] == {$past(instr[25:0]), 2'b00}));

  a_r6_taken_needs_equal: assert property (@(posedge clk) disable iff (rst)
    taken |-> (rs_val == rt_val));

  a_r8_zero_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (rs_addr == 5'd0) |-> (rs_val == 32'd0));

  a_r9_unknown_silent: assert property (@(posedge clk) disable iff (rst)
    !known_op |-> (!rf_we && !dm_we && !taken && !jump));

  a_r10_single_effect: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rf_we, dm_we, taken, jump}));
endmodule

bind subset_cpu sc_checker u_chk (
  .clk     (clk),
  .rst     (rst),
  .pc      (pc_q),
  .instr   (instr),
  .taken   (br_taken),
  .jump    (is_jump),
  .rf_we   (dbg_rf_we),
  .dm_we   (dbg_dm_we),
  .rs_addr (rs_a),
  .rs_val  (rs_val),
  .rt_val  (rt_val)
);

// File: tb/sim_subset_cpu.sv
module sim_subset_cpu;
  localparam int CLK_P = 10;
  localparam int NW    = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_en = 1'b0, ld_to_data = 1'b0;
  logic [5:0]  ld_addr = '0;
  logic [31:0] ld_word = '0;
  logic [31:0] dbg_pc, dbg_rf_wdata, dbg_dm_addr, dbg_dm_wdata;
  logic        dbg_rf_we, dbg_dm_we;
  logic [4:0]  dbg_rf_waddr;

  int total = 0, bad = 0;

  logic [31:0] m_imem [NW];
  logic [31:0] m_dmem [NW];
  logic [31:0] m_regs [32];
  logic [31:0] m_pc;
  string       pc_tag;

  always #(CLK_P/2) clk = ~clk;

  subset_cpu u0 (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_to_data(ld_to_data),
    .ld_addr(ld_addr), .ld_word(ld_word), .dbg_pc(dbg_pc),
    .dbg_rf_we(dbg_rf_we), .dbg_rf_waddr(dbg_rf_waddr),
    .dbg_rf_wdata(dbg_rf_wdata), .dbg_dm_we(dbg_dm_we),
    .dbg_dm_addr(dbg_dm_addr), .dbg_dm_wdata(dbg_dm_wdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h (pc %h)", req, act, exp, m_pc);
    end
  endtask

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd,
                                        input logic [5:0] f);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, f};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs,
                                        input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] enc_j(input int idx);
    return {6'd2, 26'(idx)};
  endfunction

  // bench-side restatement of the register-register operations (R3)
  function automatic logic [31:0] ref_rr(input logic [5:0] f, input logic [31:0] a,
                                         input logic [31:0] b);
    if (f == 6'h20) return a + b;
    if (f == 6'h22) return a + (~b) + 32'd1;
    if (f == 6'h24) return a & b;
    if (f == 6'h25) return a | b;
    if (f == 6'h27) return ~a & ~b;
    if (f == 6'h2a) begin
      if (a[31] != b[31]) return {31'd0, a[31]};
      return {31'd0, (a < b)};
    end
    return 32'd0;
  endfunction

  function automatic logic [31:0] rand_instr();
    int r = int'($urandom % 100);
    logic [5:0] fl [7] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h27, 6'h2a, 6'h3f};
    logic [5:0] bad_ops [5] = '{6'd1, 6'd3, 6'd8, 6'd15, 6'd63};
    int rs = int'($urandom % 32), rt = int'($urandom % 32), rd = int'($urandom % 32);
    int off;
    if (r < 30) return enc_i(6'd35, rs, rt, 16'($urandom));
    if (r < 42) return enc_i(6'd43, rs, rt, 16'($urandom));
    if (r < 75) return enc_r(rs, rt, rd, fl[$urandom % 7]);
    if (r < 86) begin
      off = ($urandom % 2 == 0) ? int'($urandom % 6) + 1 : -(int'($urandom % 7) + 2);
      return enc_i(6'd4, rs, ($urandom % 3 == 0) ? rs : rt, 16'(off));
    end
    if (r < 92) return enc_j(int'($urandom % NW));
    return {bad_ops[$urandom % 5], 26'($urandom)};
  endfunction

  task automatic load_word(input bit to_data, input int idx, input logic [31:0] w);
    @(negedge clk);
    ld_en = 1'b1; ld_to_data = to_data; ld_addr = 6'(idx); ld_word = w;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // holds reset, loads both arrays, checks R1, then releases reset
  task automatic start_run();
    rst = 1'b1;
    for (int i = 0; i < NW; i++) load_word(1'b0, i, m_imem[i]);
    for (int i = 0; i < NW; i++) load_word(1'b1, i, m_dmem[i]);
    @(negedge clk); #1;
    chk(dbg_pc == 32'd0, "R1 pc in reset", dbg_pc, 32'd0);
    chk(!dbg_rf_we, "R1 no reg write in reset", 32'(dbg_rf_we), 32'd0);
    chk(!dbg_dm_we, "R1 no store in reset", 32'(dbg_dm_we), 32'd0);
    for (int i = 0; i < 32; i++) m_regs[i] = 32'd0;
    m_pc = 32'd0;
    pc_tag = "R1";
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_cycles(input int n);
    for (int c = 0; c < n; c++) begin
      logic [31:0] ins, a, b, addr, val, npc;
      logic [5:0]  op;
      logic [4:0]  wa;
      bit          e_rf, e_dm;
      string       tag;
      #1;
      ins = m_imem[m_pc[7:2]];
      op  = ins[31:26];
      a   = m_regs[ins[25:21]];
      b   = m_regs[ins[20:16]];
      addr = a + {{16{ins[15]}}, ins[15:0]};
      npc = m_pc + 32'd4;
      e_rf = 1'b0; e_dm = 1'b0; wa = 5'd0; val = 32'd0;
      case (op)
        6'd0:  begin tag = "R3"; wa = ins[15:11]; val = ref_rr(ins[5:0], a, b); e_rf = 1'b1; end
        6'd35: begin tag = "R4"; wa = ins[20:16]; val = m_dmem[addr[7:2]]; e_rf = 1'b1; end
        6'd43: begin tag = "R5"; e_dm = 1'b1; end
        6'd4:  begin tag = "R6";
                 if (a == b) npc = m_pc + 32'd4 + {{14{ins[15]}}, ins[15:0], 2'b00};
               end
        6'd2:  begin tag = "R7"; npc = {npc[31:28], ins[25:0], 2'b00}; end
        default: tag = "R9";
      endcase
      if (e_rf && wa == 5'd0) begin e_rf = 1'b0; tag = "R8"; end
      // R10: outputs describe the instruction at dbg_pc in this cycle
      chk(dbg_pc == m_pc, pc_tag, dbg_pc, m_pc);
      chk(dbg_rf_we == e_rf, tag, 32'(dbg_rf_we), 32'(e_rf));
      if (e_rf) begin
        chk(dbg_rf_waddr == wa, tag, 32'(dbg_rf_waddr), 32'(wa));
        chk(dbg_rf_wdata == val, tag, dbg_rf_wdata, val);
      end
      chk(dbg_dm_we == e_dm, tag, 32'(dbg_dm_we), 32'(e_dm));
      if (e_dm) begin
        chk(dbg_dm_addr == addr, tag, dbg_dm_addr, addr);
        chk(dbg_dm_wdata == b, tag, dbg_dm_wdata, b);
      end
      if (e_rf) m_regs[wa] = val;
      if (e_dm) m_dmem[addr[7:2]] = b;
      pc_tag = (tag == "R6" || tag == "R7") ? tag : ((tag == "R9") ? "R9" : "R2");
      m_pc = npc;
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int seed_val;
    seed_val = int'($urandom(32'h1d5e));
    // directed program: signed slt, r0 discard/read, taken/untaken beq, jump, unknown codes
    for (int i = 0; i < NW; i++) begin m_imem[i] = 32'd0; m_dmem[i] = 32'h100 + 32'(i); end
    m_dmem[0] = 32'hFFFF_FFF0;
    m_dmem[1] = 32'd5;
    m_imem[0]  = enc_i(6'd35, 0, 1, 16'd0);       // R4
    m_imem[1]  = enc_i(6'd35, 0, 2, 16'd4);       // R4
    m_imem[2]  = enc_r(1, 2, 3, 6'h2a);           // R3 -16 < 5 -> 1
    m_imem[3]  = enc_r(2, 1, 4, 6'h2a);           // R3 5 < -16 -> 0
    m_imem[4]  = enc_r(1, 2, 0, 6'h20);           // R8 dropped write
    m_imem[5]  = enc_i(6'd43, 0, 0, 16'd8);       // R8 r0 reads zero, R5
    m_imem[6]  = enc_i(6'd4, 4, 0, 16'd1);        // R6 taken forward
    m_imem[7]  = 32'hFC00_0000;                   // skipped
    m_imem[8]  = enc_j(10);                       // R7
    m_imem[9]  = enc_r(1, 2, 5, 6'h20);           // skipped
    m_imem[10] = enc_r(1, 2, 6, 6'h27);           // R3 nor
    m_imem[11] = enc_i(6'd4, 1, 2, 16'hFFF4);     // R6 not taken
    m_imem[12] = 32'hFC00_0000;                   // R9
    m_imem[13] = enc_r(1, 2, 7, 6'h3f);           // R3 unknown funct -> 0
    m_imem[14] = enc_i(6'd4, 3, 3, 16'hFFF8);     // R6 taken backward to word 7
    start_run();
    run_cycles(60);

    // random programs
    for (int run = 0; run < 4; run++) begin
      for (int i = 0; i < NW; i++) begin
        m_imem[i] = rand_instr();
        m_dmem[i] = $urandom;
      end
      start_run();
      run_cycles(500);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule